// File: doc/BRIEF.md
# Dual-Channel Serial DAC Command Interface

This block is the digital front end of a two-channel, 13-bit converter. A host writes 16-bit command words over a three-wire serial link made of an active-low select, a serial clock and a data line. The block oversamples the three lines with a faster system clock and assembles each word. When select returns high, it executes the word against two double-buffered channels. Each channel holds a staging register and an output register that drives the converter. The outputs are the two output-register values, a shutdown flag and a general-purpose logic bit.

Double buffering lets software stage a new value on one channel without disturbing the converter. It can later move both staged values to the outputs in one command, or write a channel straight through. A word is executed only when exactly sixteen clock edges were captured during the select-low window. Any other count is treated as a broken transfer and dropped.

Top module: `dual_dac_cmd_if`

## Requirements
- R1: A frame is 16 bits sent most significant bit first. Bit 15 is the channel address (0 = channel A, 1 = channel B), bits 14:13 are the control code, and bits 12:0 are the data value.
- R2: After reset, both staging registers and both output values are zero, and shutdown_o and logic_o are low.
- R3: Code 00 writes the data into the staging register of the addressed channel. Neither output value changes.
- R4: Code 01 writes the data into the staging register and the output of the addressed channel. The other channel's output takes that channel's staged value.
- R5: Code 10 writes the data into both the staging register and the output of the addressed channel. The other channel is untouched.
- R6: Code 11 with address 0 copies both staging registers to their outputs.
- R7: Code 11 with address 1 sets shutdown_o and loads logic_o from data bit 12. Both output values are left unchanged.
- R8: Every executed command other than the one in R7 clears shutdown_o and leaves logic_o unchanged.
- R9: A select-low window that captures any number of serial clock rising edges other than 16 is discarded. No register or output changes.
- R10: While select is high, serial clock and data activity has no effect on any register, and it does not leak bits into the next frame.
- R11: A frame may be split into two 8-bit bursts with the serial clock idle between them. Select stays low throughout, and the two bursts are assembled into one word.
- R12: Frames are received correctly when the serial clock runs as fast as one quarter of the system clock, with each serial clock phase lasting at least two system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 4x the serial clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Serial select, active low; a rising edge commits the frame |
| sclk_i | input | 1 | Serial clock; data is sampled on its rising edge |
| din_i | input | 1 | Serial data, MSB first |
| dac_a_o | output | 13 | Output register value of channel A |
| dac_b_o | output | 13 | Output register value of channel B |
| shutdown_o | output | 1 | Shutdown flag |
| logic_o | output | 1 | User-programmable logic bit |

## Verification
A staging register cannot be seen at the ports directly. A wrong staged value therefore stays hidden until an update-all command or a code-01 write to the other channel copies it to an output. The bench issues such commands often, so this kind of corruption shows up within a few frames. A miscounted bit, a misaligned shift or a wrong decode appears on the output values or the shutdown and logic bits within a few system clocks of select rising. Each frame is checked at that point.

// File: rtl/dac_cmd_pkg.sv
package dac_cmd_pkg;
  localparam int NUM_CH = 2;

  typedef enum logic [1:0] {
    CMD_LOAD_IN  = 2'b00,
    CMD_LOAD_UPD = 2'b01,
    CMD_LOAD_OUT = 2'b10,
    CMD_SPECIAL  = 2'b11
  } cmd_e;
endpackage

// File: rtl/dac_serial_sync.sv
module dac_serial_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sclk_i,
  input  logic din_i,
  output logic cs_low_o,
  output logic cs_rise_o,
  output logic sclk_rise_o,
  output logic din_o
);
  logic [STAGES-1:0] cs_s, sclk_s, din_s;
  logic              cs_d, sclk_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_s   <= '1;
      sclk_s <= '0;
      din_s  <= '0;
      cs_d   <= 1'b1;
      sclk_d <= 1'b0;
    end else begin
      cs_s   <= {cs_s[STAGES-2:0], cs_ni};
      sclk_s <= {sclk_s[STAGES-2:0], sclk_i};
      din_s  <= {din_s[STAGES-2:0], din_i};
      cs_d   <= cs_s[STAGES-1];
      sclk_d <= sclk_s[STAGES-1];
    end
  end

  assign cs_low_o    = ~cs_s[STAGES-1];
  assign cs_rise_o   = cs_s[STAGES-1] & ~cs_d;
  assign sclk_rise_o = sclk_s[STAGES-1] & ~sclk_d;
  assign din_o       = din_s[STAGES-1];
endmodule

// File: rtl/dac_frame_shift.sv
module dac_frame_shift #(
  parameter int FRAME_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cs_low_i,
  input  logic               cs_rise_i,
  input  logic               sclk_rise_i,
  input  logic               din_i,
  output logic               frame_vld_o,
  output logic [FRAME_W-1:0] frame_o
);
  localparam int CNT_W = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);

  logic [FRAME_W-1:0] sreg_q;
  logic [CNT_W-1:0]   cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q      <= '0;
      cnt_q       <= '0;
      frame_vld_o <= 1'b0;
      frame_o     <= '0;
    end else begin
      frame_vld_o <= 1'b0;
      if (cs_rise_i && cnt_q == CNT_FULL) begin
        frame_vld_o <= 1'b1;
        frame_o     <= sreg_q;
      end
      if (!cs_low_i) begin
        cnt_q <= '0;
      end else if (sclk_rise_i) begin
        sreg_q <= {sreg_q[FRAME_W-2:0], din_i};
        // saturate so overlong frames never wrap back to a valid count
        if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dac_cmd_decode.sv
module dac_cmd_decode
  import dac_cmd_pkg::*;
#(
  parameter int DATA_W  = 13,
  parameter int FRAME_W = DATA_W + 3
) (
  input  logic               frame_vld_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic [NUM_CH-1:0]  ld_in_o,
  output logic [NUM_CH-1:0]  wr_out_o,
  output logic [NUM_CH-1:0]  upd_out_o,
  output logic               sd_set_o,
  output logic               sd_clr_o,
  output logic [DATA_W-1:0]  data_o
);
  logic addr;
  cmd_e code;

  assign addr   = frame_i[FRAME_W-1];
  assign code   = cmd_e'(frame_i[FRAME_W-2 -: 2]);
  assign data_o = frame_i[DATA_W-1:0];

  always_comb begin
    ld_in_o   = '0;
    wr_out_o  = '0;
    upd_out_o = '0;
    sd_set_o  = 1'b0;
    if (frame_vld_i) begin
      unique case (code)
        CMD_LOAD_IN: ld_in_o[addr] = 1'b1;
        CMD_LOAD_UPD: begin
          ld_in_o[addr]    = 1'b1;
          wr_out_o[addr]   = 1'b1;
          upd_out_o[~addr] = 1'b1;
        end
        CMD_LOAD_OUT: begin
          ld_in_o[addr]  = 1'b1;
          wr_out_o[addr] = 1'b1;
        end
        CMD_SPECIAL: begin
          if (addr) sd_set_o = 1'b1;
          else      upd_out_o = '1;
        end
        default: ;
      endcase
    end
  end

  assign sd_clr_o = frame_vld_i & ~sd_set_o;
endmodule

// File: rtl/dac_chan_regs.sv
module dac_chan_regs #(
  parameter int DATA_W = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_in_i,
  input  logic              wr_out_i,
  input  logic              upd_out_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] out_o
);
  logic [DATA_W-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
      out_o   <= '0;
    end else begin
      if (ld_in_i) stage_q <= data_i;
      if (wr_out_i)       out_o <= data_i;
      else if (upd_out_i) out_o <= stage_q;
    end
  end
endmodule

// File: rtl/dual_dac_cmd_if.sv
module dual_dac_cmd_if
  import dac_cmd_pkg::*;
#(
  parameter int DATA_W      = 13,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic              din_i,
  output logic [DATA_W-1:0] dac_a_o,
  output logic [DATA_W-1:0] dac_b_o,
  output logic              shutdown_o,
  output logic              logic_o
);
  localparam int FRAME_W = DATA_W + 3;

  logic               cs_low, cs_rise, sclk_rise, din_s;
  logic               frame_vld;
  logic [FRAME_W-1:0] frame_word;
  logic [NUM_CH-1:0]  ld_in, wr_out, upd_out;
  logic               sd_set, sd_clr;
  logic [DATA_W-1:0]  cmd_data;
  logic [DATA_W-1:0]  out_val [NUM_CH];

  dac_serial_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .cs_ni, .sclk_i, .din_i,
    .cs_low_o(cs_low), .cs_rise_o(cs_rise),
    .sclk_rise_o(sclk_rise), .din_o(din_s)
  );

  dac_frame_shift #(.FRAME_W(FRAME_W)) u_shift (
    .clk_i, .rst_ni,
    .cs_low_i(cs_low), .cs_rise_i(cs_rise),
    .sclk_rise_i(sclk_rise), .din_i(din_s),
    .frame_vld_o(frame_vld), .frame_o(frame_word)
  );

  dac_cmd_decode #(.DATA_W(DATA_W), .FRAME_W(FRAME_W)) u_dec (
    .frame_vld_i(frame_vld), .frame_i(frame_word),
    .ld_in_o(ld_in), .wr_out_o(wr_out), .upd_out_o(upd_out),
    .sd_set_o(sd_set), .sd_clr_o(sd_clr), .data_o(cmd_data)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    dac_chan_regs #(.DATA_W(DATA_W)) u_chan (
      .clk_i, .rst_ni,
      .ld_in_i(ld_in[ch]), .wr_out_i(wr_out[ch]), .upd_out_i(upd_out[ch]),
      .data_i(cmd_data), .out_o(out_val[ch])
    );
  end

  assign dac_a_o = out_val[0];
  assign dac_b_o = out_val[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shutdown_o <= 1'b0;
      logic_o    <= 1'b0;
    end else if (sd_set) begin
      shutdown_o <= 1'b1;
      logic_o    <= cmd_data[DATA_W-1];
    end else if (sd_clr) begin
      shutdown_o <= 1'b0;
    end
  end
endmodule

// File: rtl/dual_dac_cmd_if_chk.sv
module dual_dac_cmd_if_chk #(
  parameter int DATA_W  = 13,
  parameter int FRAME_W = DATA_W + 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               frame_vld_i,
  input logic [FRAME_W-1:0] frame_i,
  input logic [DATA_W-1:0]  dac_a_i,
  input logic [DATA_W-1:0]  dac_b_i,
  input logic               shutdown_i,
  input logic               logic_i
);
  logic       addr;
  logic [1:0] code;
  assign addr = frame_i[FRAME_W-1];
  assign code = frame_i[FRAME_W-2 -: 2];

  // R9 R10: outputs only move on an executed frame
  a_r9_hold_without_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_vld_i |=> $stable(dac_a_i) && $stable(dac_b_i) && $stable(shutdown_i) && $stable(logic_i));

  a_r3_stage_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_vld_i && code == 2'b00) |=> $stable(dac_a_i) && $stable(dac_b_i));

  a_r5_write_through_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_vld_i && code == 2'b10 && !addr) |=>
      (dac_a_i == $past(frame_i[DATA_W-1:0])) && $stable(dac_b_i));

  a_r7_shutdown_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_vld_i && code == 2'b11 && addr) |=>
      shutdown_i && (logic_i == $past(frame_i[DATA_W-1])) && $stable(dac_a_i) && $stable(dac_b_i));

  a_r8_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_vld_i && !(code == 2'b11 && addr)) |=> !shutdown_i && $stable(logic_i));
endmodule

bind dual_dac_cmd_if dual_dac_cmd_if_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .frame_vld_i(frame_vld), .frame_i(frame_word),
  .dac_a_i(dac_a_o), .dac_b_i(dac_b_o),
  .shutdown_i(shutdown_o), .logic_i(logic_o)
);

// File: tb/dual_dac_cmd_if_bench.sv
module dual_dac_cmd_if_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG       = 150000;
  localparam int SEED       = 5150;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        sclk = 1'b0;
  logic        din = 1'b0;
  logic [12:0] dac_a, dac_b;
  logic        sd, lo;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  logic [12:0] stage_m [2];
  logic [12:0] out_m [2];
  logic        sd_m, lo_m;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_dac_cmd_if u_dual_dac_cmd_if (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .din_i(din),
    .dac_a_o(dac_a), .dac_b_o(dac_b), .shutdown_o(sd), .logic_o(lo)
  );

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WDOG && !done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: act=%0d cycles exp<%0d", cyc, WDOG);
      summary();
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic check_all(string req);
    check({req, " dac_a"}, 32'(dac_a), 32'(out_m[0]));
    check({req, " dac_b"}, 32'(dac_b), 32'(out_m[1]));
    check({req, " shutdown"}, 32'(sd), 32'(sd_m));
    check({req, " logic"}, 32'(lo), 32'(lo_m));
  endtask

  task automatic wclk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bits(logic [31:0] w, int nb, int half);
    for (int i = nb - 1; i >= 0; i--) begin
      din = w[i];
      wclk(half);
      sclk = 1'b1;
      wclk(half);
      sclk = 1'b0;
    end
  endtask

  // one select window with nb bits, then settle
  task automatic send(logic [31:0] w, int nb, int half);
    cs_n = 1'b0;
    wclk(3);
    shift_bits(w, nb, half);
    wclk(3);
    cs_n = 1'b1;
    wclk(12);
  endtask

  function automatic logic [31:0] mk(logic a, logic [1:0] c, logic [12:0] d);
    return {16'h0, a, c, d};
  endfunction

  // reference behaviour from R3..R8
  task automatic model(logic a, logic [1:0] c, logic [12:0] d);
    case (c)
      2'b00: stage_m[a] = d;
      2'b01: begin stage_m[a] = d; out_m[a] = d; out_m[!a] = stage_m[!a]; end
      2'b10: begin stage_m[a] = d; out_m[a] = d; end
      default: if (a) begin sd_m = 1'b1; lo_m = d[12]; end
               else begin out_m[0] = stage_m[0]; out_m[1] = stage_m[1]; end
    endcase
    if (!(c == 2'b11 && a)) sd_m = 1'b0;
  endtask

  function automatic string tag(logic a, logic [1:0] c);
    case (c)
      2'b00: return "R3";
      2'b01: return "R4";
      2'b10: return "R5";
      default: return a ? "R7" : "R6";
    endcase
  endfunction

  task automatic cmd(logic a, logic [1:0] c, logic [12:0] d, int half, string req);
    send(mk(a, c, d), 16, half);
    model(a, c, d);
    check_all(req);
  endtask

  initial begin
    int unused_seed;
    unused_seed = $urandom(SEED);
    stage_m[0] = '0; stage_m[1] = '0;
    out_m[0] = '0; out_m[1] = '0;
    sd_m = 1'b0; lo_m = 1'b0;
    wclk(4);
    rst_n = 1'b1;
    wclk(3);
    check_all("R2 reset");

    // R1 R3: staged only, then R6 exposes it
    cmd(1'b0, 2'b00, 13'h1ABC, 4, "R3 stage A");
    cmd(1'b1, 2'b00, 13'h0123, 4, "R3 stage B");
    cmd(1'b0, 2'b11, 13'h0000, 4, "R6 update all");
    check("R1 msb-first A", 32'(dac_a), 32'h1ABC);

    cmd(1'b1, 2'b11, 13'h1000, 4, "R7 shutdown");
    check("R7 logic high", 32'(lo), 32'd1);
    cmd(1'b1, 2'b00, 13'h0555, 4, "R8 wake keeps logic");
    cmd(1'b0, 2'b01, 13'h0AAA, 4, "R4 load+update");
    cmd(1'b1, 2'b10, 13'h1111, 4, "R5 write through");

    // R9: short and long windows are dropped
    send(mk(1'b0, 2'b10, 13'h1F0F), 15, 4);
    check_all("R9 15 bits");
    send({15'h0, mk(1'b0, 2'b10, 13'h0F0F)}, 17, 4);
    check_all("R9 17 bits");
    send(32'h0, 0, 4);
    check_all("R9 empty window");

    // R10: clock noise with select high, then a clean frame
    for (int i = 0; i < 20; i++) begin
      din = i[0];
      wclk(2); sclk = 1'b1; wclk(2); sclk = 1'b0;
    end
    wclk(4);
    check_all("R10 noise ignored");
    cmd(1'b0, 2'b10, 13'h0F0F, 4, "R10 clean after noise");

    // R11: two bursts under one select window
    cs_n = 1'b0;
    wclk(3);
    shift_bits(mk(1'b1, 2'b10, 13'h1FFF) >> 8, 8, 3);
    wclk(25);
    shift_bits(mk(1'b1, 2'b10, 13'h1FFF), 8, 3);
    wclk(3);
    cs_n = 1'b1;
    wclk(12);
    model(1'b1, 2'b10, 13'h1FFF);
    check_all("R11 split frame");

    // R12: fastest serial clock
    cmd(1'b0, 2'b10, 13'h0001, 2, "R12 fast");
    cmd(1'b1, 2'b10, 13'h1000, 2, "R12 fast");

    for (int k = 0; k < 250; k++) begin
      logic        a;
      logic [1:0]  c;
      logic [12:0] d;
      int          half;
      a = 1'($urandom);
      c = 2'($urandom);
      d = 13'($urandom);
      half = 2 + int'($urandom % 4);
      if ($urandom % 10 == 0) begin
        send(mk(a, c, d), 16 + ((($urandom % 2) == 0) ? -1 : 1), half);
        check_all("R9 random bad length");
      end else begin
        cmd(a, c, d, half, tag(a, c));
      end
    end

    done = 1'b1;
    summary();
  end
endmodule